// File: doc/BRIEF.md
# USB OTG Session Request Sequencer

This block sits on the B-device side of a dual-role USB port. It watches the bus line state and runs a millisecond timebase. From these it flags an early-suspend condition and then a full suspend. While the port sits suspended and no request is being serviced, it asks the PHY to bleed VBUS away.

When software wants the host to power the bus again, it pulses a one-cycle request strobe. The block waits for two conditions: the previous session has ended (B-session-valid low) and the line has held SE0 long enough. It then pulses the data line, leaves a single tick of quiet, and pulses charge onto VBUS. After that it waits for the host to turn VBUS on. The outcome is recorded in sticky status flags, and an interrupt is raised.

The millisecond base is derived from an input tick through a parameterised prescaler, so a simulation can use short intervals. Line state is encoded as 2'b00 = J (idle), 2'b01 = K, 2'b10 = SE0 and 2'b11 = SE1. The clear-strobe bits are [0] early suspend, [1] suspend, [2] request success and [3] request failure.

Top module: `srp_seq`

## Requirements
- R1: While reset is asserted and on leaving it, every output is low and every status flag is clear.
- R2: The early-suspend flag rises once the line has stayed J or SE0 for EARLY_MS milliseconds, and not before.
- R3: The suspend flag rises after SUSP_MS milliseconds of unbroken idle. The discharge request is high while that idle time holds and the sequencer is idle or waiting to start, and never together with charge.
- R4: A K or SE1 line state restarts the idle and SE0 timing, and it drops the discharge request on the next cycle.
- R5: An accepted request starts data-line pulsing only once SE0 has lasted SE0_MS milliseconds and B-session-valid is low. A request that arrives before then is held until both are true.
- R6: The data-line pulse lasts DP_MS milliseconds. Exactly one tick follows with neither output active. Charge then lasts vb_pulse_ms milliseconds, where a value of zero acts as one. Data-line pulse and charge are never high together.
- R7: VBUS-valid seen during pulsing, the gap or the response wait ends the sequence. Both pulse outputs go low, and the success flag is set on the next cycle.
- R8: If VBUS-valid does not appear within resp_timeout_ms milliseconds after charge ends, the failure flag is set and the sequencer returns to idle.
- R9: A request strobe that arrives while a sequence is running is ignored, and no second sequence follows.
- R10: Status flags stay set until the matching flag_clr bit is written with one. The interrupt is high whenever the success flag or the failure flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Timebase tick feeding the millisecond prescaler |
| line_st | input | 2 | Line state: 00 J, 01 K, 10 SE0, 11 SE1 |
| vbus_valid | input | 1 | VBUS valid from the PHY |
| b_sess_valid | input | 1 | B-session valid from the PHY |
| sess_req | input | 1 | One-cycle session-request strobe from software |
| vb_pulse_ms | input | 8 | Charge pulse length in milliseconds |
| resp_timeout_ms | input | 8 | Wait for host VBUS after charge, in milliseconds |
| flag_clr | input | 4 | Write-one-to-clear strobes for the status flags |
| dischrg_vbus | output | 1 | Discharge request to the PHY |
| chrg_vbus | output | 1 | Charge (VBUS pulse) request to the PHY |
| dp_pulse | output | 1 | Data-line pulse enable |
| early_susp | output | 1 | Early-suspend status flag |
| susp | output | 1 | Suspend status flag |
| srp_ok | output | 1 | Session request succeeded |
| srp_fail | output | 1 | Session request timed out |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach from the ports is the held request. In that state the strobe has already been accepted, but the start is still blocked, either because SE0 is too short or because B-session-valid is high. The bench reaches it in two ways. In one, it issues the strobe in the same cycle that SE0 begins. In the other, it keeps B-session-valid high over a long SE0, confirms that no pulse appears, and then drops B-session-valid. Pulse lengths and the single-tick gap are measured by counting cycles at the outputs. The prescaler phase is not visible from outside, so each length is accepted within a one-millisecond window.

// File: rtl/srp_seq.sv
module srp_seq #(
  parameter int TICKS_PER_MS = 1000,
  parameter int EARLY_MS     = 3,
  parameter int SUSP_MS      = 10,
  parameter int SE0_MS       = 2,
  parameter int DP_MS        = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] line_st,
  input  logic       vbus_valid,
  input  logic       b_sess_valid,
  input  logic       sess_req,
  input  logic [7:0] vb_pulse_ms,
  input  logic [7:0] resp_timeout_ms,
  input  logic [3:0] flag_clr,
  output logic       dischrg_vbus,
  output logic       chrg_vbus,
  output logic       dp_pulse,
  output logic       early_susp,
  output logic       susp,
  output logic       srp_ok,
  output logic       srp_fail,
  output logic       irq
);
  localparam int PW = $clog2(TICKS_PER_MS + 1);
  localparam int IW = $clog2(SUSP_MS + 1);
  localparam int SW = $clog2(SE0_MS + 1);
  localparam int CW = 8;
  localparam logic [1:0] LS_J   = 2'b00;
  localparam logic [1:0] LS_SE0 = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_DP, S_GAP, S_VB, S_WAIT} st_t;

  logic [PW-1:0] pre;
  logic [IW-1:0] idle_cnt;
  logic [SW-1:0] se0_cnt;
  logic [CW-1:0] ph_cnt, len;
  st_t           state, nstate;

  wire ms       = tick && (pre == PW'(TICKS_PER_MS - 1));
  wire quiet    = (line_st == LS_J) || (line_st == LS_SE0);
  wire on_se0   = (line_st == LS_SE0);
  wire susp_det = (idle_cnt == IW'(SUSP_MS));
  wire se0_ok   = (se0_cnt == SW'(SE0_MS));
  wire early_hit = quiet && ms && (idle_cnt == IW'(EARLY_MS - 1));
  wire susp_hit  = quiet && ms && (idle_cnt == IW'(SUSP_MS - 1));
  wire pulsing   = (state == S_DP) || (state == S_GAP) || (state == S_VB) || (state == S_WAIT);
  wire ph_last   = ms && (({1'b0, ph_cnt} + 9'd1) >= {1'b0, len});
  wire ok_hit    = pulsing && vbus_valid;
  wire fail_hit  = (state == S_WAIT) && !vbus_valid && ph_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else if (tick) pre <= ms ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idle_cnt <= '0;
    else if (!quiet) idle_cnt <= '0;
    else if (ms && !susp_det) idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) se0_cnt <= '0;
    else if (!on_se0) se0_cnt <= '0;
    else if (ms && !se0_ok) se0_cnt <= se0_cnt + 1'b1;

  always_comb
    case (state)
      S_DP:    len = CW'(DP_MS);
      S_VB:    len = vb_pulse_ms;
      default: len = resp_timeout_ms;
    endcase

  always_comb begin
    nstate = state;
    case (state)
      S_IDLE: if (sess_req) nstate = S_ARM;
      S_ARM:  if (se0_ok && !b_sess_valid) nstate = S_DP;
      S_DP:   if (vbus_valid) nstate = S_IDLE; else if (ph_last) nstate = S_GAP;
      S_GAP:  if (vbus_valid) nstate = S_IDLE; else if (tick) nstate = S_VB;
      S_VB:   if (vbus_valid) nstate = S_IDLE; else if (ph_last) nstate = S_WAIT;
      S_WAIT: if (vbus_valid || ph_last) nstate = S_IDLE;
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      ph_cnt <= '0;
    end else begin
      state <= nstate;
      if (nstate != state) ph_cnt <= '0;
      else if (ms && pulsing) ph_cnt <= ph_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      early_susp <= 1'b0;
      susp       <= 1'b0;
      srp_ok     <= 1'b0;
      srp_fail   <= 1'b0;
    end else begin
      early_susp <= early_hit || (early_susp && !flag_clr[0]);
      susp       <= susp_hit  || (susp       && !flag_clr[1]);
      srp_ok     <= ok_hit    || (srp_ok     && !flag_clr[2]);
      srp_fail   <= fail_hit  || (srp_fail   && !flag_clr[3]);
    end

  assign dp_pulse     = (state == S_DP);
  assign chrg_vbus    = (state == S_VB);
  assign dischrg_vbus = susp_det && ((state == S_IDLE) || (state == S_ARM));
  assign irq          = srp_ok || srp_fail;

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_pulse && chrg_vbus));
  assert_gap_before_charge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrg_vbus) |-> !$past(dp_pulse));
  assert_no_dischrg_with_chrg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dischrg_vbus && chrg_vbus));
  assert_start_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_pulse) |-> ($past(se0_cnt) == SW'(SE0_MS)) && !$past(b_sess_valid));
  assert_ok_stops_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srp_ok) |-> !dp_pulse && !chrg_vbus);
  assert_fail_from_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srp_fail) |-> $past(state) == S_WAIT);
  assert_busy_req_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_req && state != S_IDLE) |=> (state != S_ARM || $past(state) == S_ARM));
  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (srp_fail && !flag_clr[3]) |=> srp_fail);
endmodule

// File: tb/srp_seq_tb_top.sv
module srp_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int EM = 3;
  localparam int SM = 6;
  localparam int DM = 3;

  logic clk = 0, rst_n = 0, tick = 1;
  logic [1:0] line_st = 2'b01;
  logic vbus_valid = 0, b_sess_valid = 0, sess_req = 0;
  logic [7:0] vb_pulse_ms = 8'd2, resp_timeout_ms = 8'd3;
  logic [3:0] flag_clr = 0;
  logic dischrg_vbus, chrg_vbus, dp_pulse, early_susp, susp, srp_ok, srp_fail, irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srp_seq #(.TICKS_PER_MS(N), .EARLY_MS(EM), .SUSP_MS(SM), .SE0_MS(2), .DP_MS(DM)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_st(line_st), .vbus_valid(vbus_valid),
    .b_sess_valid(b_sess_valid), .sess_req(sess_req), .vb_pulse_ms(vb_pulse_ms),
    .resp_timeout_ms(resp_timeout_ms), .flag_clr(flag_clr), .dischrg_vbus(dischrg_vbus),
    .chrg_vbus(chrg_vbus), .dp_pulse(dp_pulse), .early_susp(early_susp), .susp(susp),
    .srp_ok(srp_ok), .srp_fail(srp_fail), .irq(irq));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    sess_req = 1; step(1); sess_req = 0;
  endtask

  task automatic clear_flags(input logic [3:0] m);
    flag_clr = m; step(1); flag_clr = 0;
  endtask

  task automatic t_reset();
    step(1);
    chk({dischrg_vbus, chrg_vbus, dp_pulse, early_susp, susp, srp_ok, srp_fail, irq} == 0,
        "R1 outputs in reset", {dischrg_vbus, chrg_vbus, dp_pulse, early_susp, susp, srp_ok, srp_fail, irq}, 0);
    rst_n = 1; step(1);
    chk({dischrg_vbus, chrg_vbus, dp_pulse, early_susp, susp, srp_ok, srp_fail, irq} == 0,
        "R1 outputs after reset", {dischrg_vbus, chrg_vbus, dp_pulse, early_susp, susp, srp_ok, srp_fail, irq}, 0);
  endtask

  task automatic t_suspend();
    line_st = 2'b00;
    step(2*N);     chk(!early_susp, "R2 early too soon", early_susp, 0);
    step(N+2);     chk(early_susp, "R2 early set", early_susp, 1);
    step(2*N-2);   chk(!susp && !dischrg_vbus, "R3 suspend too soon", {susp, dischrg_vbus}, 0);
    step(N+2);     chk(susp && dischrg_vbus, "R3 suspend and discharge", {susp, dischrg_vbus}, 3);
    chk(!irq, "R10 no irq from suspend", irq, 0);
  endtask

  task automatic t_activity();
    line_st = 2'b01; step(1);
    chk(!dischrg_vbus, "R4 discharge drops on K", dischrg_vbus, 0);
    chk(early_susp && susp, "R10 flags sticky", {early_susp, susp}, 3);
    clear_flags(4'b0011);
    chk(!early_susp && !susp, "R10 w1c clears", {early_susp, susp}, 0);
    line_st = 2'b00; step(2*N);
    line_st = 2'b11; step(1);
    line_st = 2'b00; step(2*N-1);
    chk(!early_susp, "R4 restart after SE1", early_susp, 0);
    line_st = 2'b01; step(1);
  endtask

  task automatic wait_dp(input string tag);
    int w = 0;
    while (!dp_pulse && w < 8*N) begin step(1); w++; end
    chk(dp_pulse, tag, dp_pulse, 1);
  endtask

  task automatic run_dp_gap(input bool_t_unused = 0);
    int d = 0;
    while (dp_pulse && d < 100) begin
      sess_req = (d == 1); step(1); d++;
    end
    sess_req = 0;
    chk(d >= (DM-1)*N+1 && d <= DM*N, "R6 data-line pulse length", d, DM*N);
    chk(!chrg_vbus && !dp_pulse, "R6 quiet gap", {dp_pulse, chrg_vbus}, 0);
    step(1);
    chk(chrg_vbus && !dp_pulse, "R6 charge after one tick", {dp_pulse, chrg_vbus}, 2);
  endtask

  task automatic t_srp_ok();
    vb_pulse_ms = 8'd2; line_st = 2'b10; b_sess_valid = 0;
    pulse_req();
    step(N-2);
    chk(!dp_pulse, "R5 held until SE0 time", dp_pulse, 0);
    wait_dp("R5 pulse starts after SE0 time");
    run_dp_gap();
    vbus_valid = 1; step(1);
    chk(!chrg_vbus && !dp_pulse && srp_ok && irq, "R7 success ends charge",
        {chrg_vbus, dp_pulse, srp_ok, irq}, 3);
    vbus_valid = 0;
    step(3*N);
    chk(!dp_pulse && !chrg_vbus, "R9 busy request not queued", {dp_pulse, chrg_vbus}, 0);
    clear_flags(4'b0100);
    chk(!srp_ok && !irq, "R10 success cleared", {srp_ok, irq}, 0);
  endtask

  task automatic t_srp_fail();
    int c = 0;
    int w = 0;
    vb_pulse_ms = 8'd0; resp_timeout_ms = 8'd2;
    pulse_req();
    wait_dp("R5 second sequence starts");
    run_dp_gap();
    while (chrg_vbus && c < 100) begin step(1); c++; end
    chk(c >= 1 && c <= N, "R6 zero charge length acts as one", c, N);
    while (!srp_fail && w < 100) begin step(1); w++; end
    chk(w >= N+1 && w <= 2*N+1, "R8 timeout length", w, 2*N);
    chk(srp_fail && irq && !srp_ok, "R8 failure flagged", {srp_fail, irq, srp_ok}, 6);
    step(2*N);
    chk(srp_fail && !dp_pulse && !chrg_vbus, "R8 idle after failure", {srp_fail, dp_pulse, chrg_vbus}, 4);
    clear_flags(4'b1000);
    chk(!srp_fail && !irq, "R10 failure cleared", {srp_fail, irq}, 0);
  endtask

  task automatic t_bsess_gate();
    b_sess_valid = 1;
    pulse_req();
    step(4*N);
    chk(!dp_pulse, "R5 blocked by session valid", dp_pulse, 0);
    b_sess_valid = 0; step(2);
    chk(dp_pulse, "R5 starts when session ends", dp_pulse, 1);
    vbus_valid = 1; step(1);
    chk(!dp_pulse && srp_ok, "R7 success during data-line pulse", {dp_pulse, srp_ok}, 1);
    vbus_valid = 0;
    clear_flags(4'b0100);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    t_suspend();
    t_activity();
    t_srp_ok();
    t_srp_fail();
    t_bsess_gate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule